// File: doc/BRIEF.md
# Parallel NOR Program Command Sequencer

This block sits on the host side of a parallel NOR flash. It turns requests into the bus write cycles the flash expects. The host presents an operation code, a word address, a data word and, for buffered programming, a word count on a valid/ready interface. The sequencer then drives chip enable, write enable, output enable, the address bus and the data bus through the whole command sequence. Only when the last write cycle has finished does it take the next request.

It keeps track of whether the flash is in unlock-bypass mode. In that mode a word program needs two write cycles instead of four, and a buffered program skips the two unlock cycles. A buffered program carries up to `MAX_BUF` words. The host supplies those words one at a time on a separate valid/ready word port. The sequencer can also issue sector-erase and chip-erase command sequences. It does not poll the flash for completion.

The low time and the high time of every write strobe are set from two configuration inputs. Both are sampled when a request is accepted. After reset the sequencer assumes the flash is reading its array and sends no command of its own.

Top module: `norProgSeq`

## Requirements
- R1: After reset, flashCeN, flashWeN and flashOeN are high, reqReady is 1, reqReject and wordReady are 0, and bypass mode is off. The first word program therefore takes four write cycles.
- R2: A word program (reqOp=0) outside bypass mode issues four write cycles, given as data@address: 0x00AA@0x555, 0x0055@0x2AA, 0x00A0@0x555, then reqData@reqAddr.
- R3: In every write cycle, flashCeN and flashWeN are low together and flashOeN stays high. flashOeN is never driven low.
- R4: Each strobe stays low for max(cfgLowCycles,1) cycles. Between consecutive write cycles, and after the last one, strobes stay high for max(cfgHighCycles,1) cycles. Both settings are sampled when the request is accepted.
- R5: reqReady drops in the cycle after a request is accepted. It stays low until the high time of the last write cycle has elapsed, then returns to 1.
- R6: Bypass entry (reqOp=2) issues 0x00AA@0x555, 0x0055@0x2AA, 0x0020@0x555 and turns bypass mode on. From then on a word program issues only 0x00A0@0x555 and reqData@reqAddr. An entry request while bypass mode is already on issues no write cycle.
- R7: Bypass exit (reqOp=3) while bypass mode is on issues 0x0090@0x000 and then 0x0000@0x000, and turns bypass mode off. An exit request while bypass mode is off issues no write cycle.
- R8: A buffered program (reqOp=1) with count N issues, in order:
  - the two unlock cycles, only when bypass mode is off;
  - 0x0025@A;
  - (N-1)@A;
  - N cycles of word i @ A+i, for i from 0 to N-1;
  - 0x0029@A.
  Here A is reqAddr. Each word is taken through one wordValid/wordReady handshake. While the block waits for a word, the strobes stay high.
- R9: The block rejects a request whose operation code is 6 or 7, or a buffered program with N=0 or N>MAX_BUF. For a rejected request reqReject is 1 for exactly the cycle after acceptance and no write cycle is issued.
- R10: Sector erase (reqOp=4) issues 0x00AA@0x555, 0x0055@0x2AA, 0x0080@0x555, 0x00AA@0x555, 0x0055@0x2AA, 0x0030@reqAddr. Chip erase (reqOp=5) issues the same sequence but ends with 0x0010@0x555.
- R11: While bypass mode is on, the block rejects both erase operations as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgLowCycles | input | TIMER_W | Strobe low time in cycles (0 treated as 1) |
| cfgHighCycles | input | TIMER_W | Strobe high time in cycles (0 treated as 1) |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Request ready, low while a sequence runs |
| reqOp | input | 3 | 0 program, 1 buffered program, 2 bypass entry, 3 bypass exit, 4 sector erase, 5 chip erase |
| reqAddr | input | ADDR_W | Target word address |
| reqData | input | DATA_W | Program data word |
| reqCount | input | BCNT_W | Word count of a buffered program |
| reqReject | output | 1 | One-cycle pulse for a rejected request |
| wordValid | input | 1 | Buffered word available |
| wordReady | output | 1 | Sequencer takes a buffered word |
| wordData | input | DATA_W | Buffered word |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashAddr | output | ADDR_W | Flash word address |
| flashData | output | DATA_W | Flash data bus, driven toward the flash |

## Verification
The bench builds the block with MAX_BUF=4, keeping the other parameters at their defaults. With that setting, a full buffer of four words and an over-length request of five words both fit into a short run. The default 4-bit timer lets the bench set strobe times of 0, 2 and 3 cycles, so the zero-means-one rule and longer low and high windows are both exercised. Bypass mode is entered and left while the table runs, which places the two-cycle program, the shortened buffered sequence and the erase rejection in the same pass.

// File: rtl/norSeqPkg.sv
package norSeqPkg;

  localparam logic [2:0] OP_PROG       = 3'd0;
  localparam logic [2:0] OP_BUF        = 3'd1;
  localparam logic [2:0] OP_BYP_ON     = 3'd2;
  localparam logic [2:0] OP_BYP_OFF    = 3'd3;
  localparam logic [2:0] OP_ERASE_SECT = 3'd4;
  localparam logic [2:0] OP_ERASE_CHIP = 3'd5;

  typedef enum logic [3:0] {
    PH_UNL1,
    PH_UNL2,
    PH_PROGCMD,
    PH_TARGET,
    PH_BYPCMD,
    PH_EXIT1,
    PH_EXIT2,
    PH_BUFCMD,
    PH_BUFCNT,
    PH_BUFWORD,
    PH_BUFCONF,
    PH_ERASE80,
    PH_ERSECT,
    PH_ERCHIP
  } phaseE;

  typedef struct packed {
    phaseE phase;
    logic  last;
  } stepInfoS;

  typedef struct packed {
    logic  loadReq;
    logic  loadWord;
    logic  nextWord;
    logic  timerClr;
    phaseE phase;
  } dpStrobeS;

endpackage

// File: rtl/norSeqDatapath.sv
module norSeqDatapath
  import norSeqPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int TIMER_W = 4,
  parameter int MAX_BUF = 16,
  parameter int BCNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeS          strobe,
  input  logic [TIMER_W-1:0] cfgLowCycles,
  input  logic [TIMER_W-1:0] cfgHighCycles,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BCNT_W-1:0] reqCount,
  input  logic [DATA_W-1:0] wordData,
  output logic              lowDone,
  output logic              highDone,
  output logic              lastWord,
  output logic              countBad,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashData
);

  localparam logic [ADDR_W-1:0] ADR_555 = ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] ADR_2AA = ADDR_W'(12'h2AA);
  localparam logic [ADDR_W-1:0] ADR_000 = '0;
  localparam logic [BCNT_W-1:0] CNT_MAX = BCNT_W'(MAX_BUF);

  logic [ADDR_W-1:0]  addrReg;
  logic [DATA_W-1:0]  dataReg;
  logic [DATA_W-1:0]  wordReg;
  logic [BCNT_W-1:0]  cntReg;
  logic [BCNT_W-1:0]  wordIdx;
  logic [TIMER_W-1:0] lowLen;
  logic [TIMER_W-1:0] highLen;
  logic [TIMER_W-1:0] timer;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      wordReg <= '0;
      cntReg  <= '0;
      wordIdx <= '0;
      lowLen  <= TIMER_W'(1);
      highLen <= TIMER_W'(1);
      timer   <= '0;
    end else begin
      if (strobe.loadReq) begin
        addrReg <= reqAddr;
        dataReg <= reqData;
        cntReg  <= reqCount;
        wordIdx <= '0;
        lowLen  <= (cfgLowCycles == '0) ? TIMER_W'(1) : cfgLowCycles;
        highLen <= (cfgHighCycles == '0) ? TIMER_W'(1) : cfgHighCycles;
      end
      if (strobe.loadWord) wordReg <= wordData;
      if (strobe.nextWord) wordIdx <= wordIdx + BCNT_W'(1);
      if (strobe.timerClr) timer <= '0;
      else                 timer <= timer + TIMER_W'(1);
    end
  end

  assign lowDone  = (timer == lowLen - TIMER_W'(1));
  assign highDone = (timer == highLen - TIMER_W'(1));
  assign lastWord = (wordIdx == cntReg - BCNT_W'(1));
  assign countBad = (reqCount == '0) || (reqCount > CNT_MAX);

  always_comb begin
    flashAddr = ADR_555;
    flashData = '0;
    unique case (strobe.phase)
      PH_UNL1:    begin flashAddr = ADR_555; flashData = DATA_W'(8'hAA); end
      PH_UNL2:    begin flashAddr = ADR_2AA; flashData = DATA_W'(8'h55); end
      PH_PROGCMD: begin flashAddr = ADR_555; flashData = DATA_W'(8'hA0); end
      PH_TARGET:  begin flashAddr = addrReg; flashData = dataReg; end
      PH_BYPCMD:  begin flashAddr = ADR_555; flashData = DATA_W'(8'h20); end
      PH_EXIT1:   begin flashAddr = ADR_000; flashData = DATA_W'(8'h90); end
      PH_EXIT2:   begin flashAddr = ADR_000; flashData = '0; end
      PH_BUFCMD:  begin flashAddr = addrReg; flashData = DATA_W'(8'h25); end
      PH_BUFCNT:  begin flashAddr = addrReg; flashData = DATA_W'(cntReg - BCNT_W'(1)); end
      PH_BUFWORD: begin flashAddr = addrReg + ADDR_W'(wordIdx); flashData = wordReg; end
      PH_BUFCONF: begin flashAddr = addrReg; flashData = DATA_W'(8'h29); end
      PH_ERASE80: begin flashAddr = ADR_555; flashData = DATA_W'(8'h80); end
      PH_ERSECT:  begin flashAddr = addrReg; flashData = DATA_W'(8'h30); end
      PH_ERCHIP:  begin flashAddr = ADR_555; flashData = DATA_W'(8'h10); end
      default:    begin flashAddr = ADR_555; flashData = '0; end
    endcase
  end

endmodule

// File: rtl/norSeqCtrl.sv
module norSeqCtrl
  import norSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [2:0] reqOp,
  input  logic       countBad,
  input  logic       lowDone,
  input  logic       highDone,
  input  logic       lastWord,
  input  logic       wordValid,
  output logic       reqReady,
  output logic       reqReject,
  output logic       wordReady,
  output logic       weLow,
  output dpStrobeS   strobe
);

  typedef enum logic [2:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_WAIT, ST_RESP} stateE;

  stateE      state, stateN;
  logic [2:0] opReg, opN;
  logic       bypReg, bypN;
  logic       rejReg, rejN;
  logic [3:0] stepReg, stepN;
  stepInfoS   curInfo;
  logic       rejectNow, noopNow;

  function automatic stepInfoS seqStep(input logic [2:0] op, input logic byp,
                                       input logic [3:0] step);
    stepInfoS r;
    logic [3:0] s;
    r.phase = PH_UNL1;
    r.last  = 1'b0;
    s = step;
    case (op)
      OP_PROG: begin
        if (byp) s = step + 4'd2;
        case (s)
          4'd0:    r.phase = PH_UNL1;
          4'd1:    r.phase = PH_UNL2;
          4'd2:    r.phase = PH_PROGCMD;
          default: begin r.phase = PH_TARGET; r.last = 1'b1; end
        endcase
      end
      OP_BUF: begin
        if (byp) s = step + 4'd2;
        case (s)
          4'd0:    r.phase = PH_UNL1;
          4'd1:    r.phase = PH_UNL2;
          4'd2:    r.phase = PH_BUFCMD;
          4'd3:    r.phase = PH_BUFCNT;
          4'd4:    r.phase = PH_BUFWORD;
          default: begin r.phase = PH_BUFCONF; r.last = 1'b1; end
        endcase
      end
      OP_BYP_ON: begin
        case (s)
          4'd0:    r.phase = PH_UNL1;
          4'd1:    r.phase = PH_UNL2;
          default: begin r.phase = PH_BYPCMD; r.last = 1'b1; end
        endcase
      end
      OP_BYP_OFF: begin
        if (s == 4'd0) r.phase = PH_EXIT1;
        else begin r.phase = PH_EXIT2; r.last = 1'b1; end
      end
      default: begin
        case (s)
          4'd0, 4'd3: r.phase = PH_UNL1;
          4'd1, 4'd4: r.phase = PH_UNL2;
          4'd2:       r.phase = PH_ERASE80;
          default: begin
            r.phase = (op == OP_ERASE_CHIP) ? PH_ERCHIP : PH_ERSECT;
            r.last  = 1'b1;
          end
        endcase
      end
    endcase
    return r;
  endfunction

  assign curInfo = seqStep(opReg, bypReg, stepReg);

  always_comb begin
    rejectNow = (reqOp > OP_ERASE_CHIP)
             || ((reqOp == OP_BUF) && countBad)
             || (((reqOp == OP_ERASE_SECT) || (reqOp == OP_ERASE_CHIP)) && bypReg);
    noopNow   = ((reqOp == OP_BYP_ON) && bypReg) || ((reqOp == OP_BYP_OFF) && !bypReg);
  end

  always_comb begin
    strobe          = '0;
    strobe.phase    = curInfo.phase;
    stateN          = state;
    opN             = opReg;
    bypN            = bypReg;
    rejN            = rejReg;
    stepN           = stepReg;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq  = 1'b1;
          strobe.timerClr = 1'b1;
          opN   = reqOp;
          stepN = '0;
          if (rejectNow || noopNow) begin
            stateN = ST_RESP;
            rejN   = rejectNow;
          end else begin
            stateN = ST_LOW;
          end
        end
      end
      ST_LOW: begin
        if (lowDone) begin
          strobe.timerClr = 1'b1;
          stateN = ST_HIGH;
        end
      end
      ST_HIGH: begin
        if (highDone) begin
          strobe.timerClr = 1'b1;
          if ((curInfo.phase == PH_BUFWORD) && !lastWord) begin
            strobe.nextWord = 1'b1;
            stateN = ST_WAIT;
          end else if (curInfo.last) begin
            stateN = ST_IDLE;
            if (opReg == OP_BYP_ON)  bypN = 1'b1;
            if (opReg == OP_BYP_OFF) bypN = 1'b0;
          end else begin
            stepN  = stepReg + 4'd1;
            stateN = (seqStep(opReg, bypReg, stepReg + 4'd1).phase == PH_BUFWORD)
                     ? ST_WAIT : ST_LOW;
          end
        end
      end
      ST_WAIT: begin
        if (wordValid) begin
          strobe.loadWord = 1'b1;
          strobe.timerClr = 1'b1;
          stateN = ST_LOW;
        end
      end
      ST_RESP: begin
        stateN = ST_IDLE;
        rejN   = 1'b0;
      end
      default: stateN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= OP_PROG;
      bypReg  <= 1'b0;
      rejReg  <= 1'b0;
      stepReg <= '0;
    end else begin
      state   <= stateN;
      opReg   <= opN;
      bypReg  <= bypN;
      rejReg  <= rejN;
      stepReg <= stepN;
    end
  end

  assign reqReady  = (state == ST_IDLE);
  assign reqReject = (state == ST_RESP) && rejReg;
  assign wordReady = (state == ST_WAIT);
  assign weLow     = (state == ST_LOW);

endmodule

// File: rtl/norProgSeq.sv
module norProgSeq
  import norSeqPkg::*;
#(
  parameter int ADDR_W  = 24,
  parameter int DATA_W  = 16,
  parameter int TIMER_W = 4,
  parameter int MAX_BUF = 16,
  parameter int BCNT_W  = $clog2(MAX_BUF) + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [TIMER_W-1:0] cfgLowCycles,
  input  logic [TIMER_W-1:0] cfgHighCycles,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [2:0]         reqOp,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqData,
  input  logic [BCNT_W-1:0]  reqCount,
  output logic               reqReject,
  input  logic               wordValid,
  output logic               wordReady,
  input  logic [DATA_W-1:0]  wordData,
  output logic               flashCeN,
  output logic               flashWeN,
  output logic               flashOeN,
  output logic [ADDR_W-1:0]  flashAddr,
  output logic [DATA_W-1:0]  flashData
);

  dpStrobeS strobe;
  logic     lowDone, highDone, lastWord, countBad, weLow;

  norSeqCtrl ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
    .countBad(countBad), .lowDone(lowDone), .highDone(highDone),
    .lastWord(lastWord), .wordValid(wordValid), .reqReady(reqReady),
    .reqReject(reqReject), .wordReady(wordReady), .weLow(weLow),
    .strobe(strobe)
  );

  norSeqDatapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIMER_W(TIMER_W),
    .MAX_BUF(MAX_BUF), .BCNT_W(BCNT_W)
  ) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cfgLowCycles(cfgLowCycles), .cfgHighCycles(cfgHighCycles),
    .reqAddr(reqAddr), .reqData(reqData), .reqCount(reqCount),
    .wordData(wordData), .lowDone(lowDone), .highDone(highDone),
    .lastWord(lastWord), .countBad(countBad),
    .flashAddr(flashAddr), .flashData(flashData)
  );

  assign flashCeN = !weLow;
  assign flashWeN = !weLow;
  assign flashOeN = 1'b1;

endmodule

// File: rtl/norProgSeqChecker.sv
module norProgSeqChecker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              reqReject,
  input logic              wordReady,
  input logic              flashWeN,
  input logic              flashOeN,
  input logic [ADDR_W-1:0] flashAddr,
  input logic [DATA_W-1:0] flashData
);

  // R5: accepting a request drops ready on the next cycle
  a_r5_accept_drops_ready: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R5: no strobe while the block says it is ready
  a_r5_busy_while_strobing: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> !reqReady);

  // R3: output enable stays high during every write strobe
  a_r3_oe_high: assert property (@(posedge clk) disable iff (!rstN)
    !flashWeN |-> flashOeN);

  // R2: address and data hold steady across a strobe low window
  a_r2_bus_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!flashWeN && $past(!flashWeN)) |-> ($stable(flashAddr) && $stable(flashData)));

  // R9: a rejection issues no strobe and keeps the request port closed
  a_r9_reject_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReject |-> (flashWeN && !reqReady));

  // R8: strobes stay high while a buffered word is awaited
  a_r8_wait_quiet: assert property (@(posedge clk) disable iff (!rstN)
    wordReady |-> (flashWeN && !reqReady));

endmodule

bind norProgSeq norProgSeqChecker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqReject(reqReject), .wordReady(wordReady), .flashWeN(flashWeN),
  .flashOeN(flashOeN), .flashAddr(flashAddr), .flashData(flashData)
);

// File: tb/norProgSeq_test.sv
module norProgSeq_test;

  localparam int ADDR_W  = 24;
  localparam int DATA_W  = 16;
  localparam int TIMER_W = 4;
  localparam int MAX_BUF = 4;
  localparam int BCNT_W  = $clog2(MAX_BUF) + 2;
  localparam int LOGSZ   = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [TIMER_W-1:0] cfgLowCycles = 4'd2;
  logic [TIMER_W-1:0] cfgHighCycles = 4'd1;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [2:0] reqOp = 3'd0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic [BCNT_W-1:0] reqCount = '0;
  logic reqReject;
  logic wordValid = 1'b1;
  logic wordReady;
  logic [DATA_W-1:0] wordData;
  logic flashCeN, flashWeN, flashOeN;
  logic [ADDR_W-1:0] flashAddr;
  logic [DATA_W-1:0] flashData;

  norProgSeq #(.MAX_BUF(MAX_BUF)) uut (
    .clk(clk), .rstN(rstN), .cfgLowCycles(cfgLowCycles), .cfgHighCycles(cfgHighCycles),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .reqCount(reqCount), .reqReject(reqReject),
    .wordValid(wordValid), .wordReady(wordReady), .wordData(wordData),
    .flashCeN(flashCeN), .flashWeN(flashWeN), .flashOeN(flashOeN),
    .flashAddr(flashAddr), .flashData(flashData)
  );

  always #5 clk = ~clk;

  // word source: counts handshakes, data = base + count
  logic [DATA_W-1:0] wordBase = 16'h0;
  int wordCnt = 0;
  always @(posedge clk) if (wordValid && wordReady) wordCnt <= wordCnt + 1;
  assign wordData = wordBase + DATA_W'(wordCnt);

  // bus monitor
  int logN = 0, lowRun = 0, gapRun = 0, oeBad = 0, ceBad = 0;
  logic prevWe = 1'b1;
  logic [ADDR_W-1:0] curA;
  logic [DATA_W-1:0] curD;
  logic [ADDR_W-1:0] logA [LOGSZ];
  logic [DATA_W-1:0] logD [LOGSZ];
  int logLow [LOGSZ];
  int logGap [LOGSZ];
  always @(negedge clk) begin
    if (!flashOeN) oeBad = oeBad + 1;
    if (!flashWeN) begin
      if (flashCeN) ceBad = ceBad + 1;
      if (prevWe) logGap[logN % LOGSZ] = gapRun;
      lowRun = lowRun + 1;
      curA = flashAddr;
      curD = flashData;
    end else if (!prevWe) begin
      logA[logN % LOGSZ] = curA;
      logD[logN % LOGSZ] = curD;
      logLow[logN % LOGSZ] = lowRun;
      logN = logN + 1;
      lowRun = 0;
      gapRun = reqReady ? 0 : 1;
    end else if (!reqReady) begin
      gapRun = gapRun + 1;
    end
    prevWe = flashWeN;
  end

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // expected write list, built from the requirements
  logic [ADDR_W-1:0] expA [32];
  logic [DATA_W-1:0] expD [32];
  bit bypModel = 0;

  task automatic push(inout int n, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    expA[n] = a; expD[n] = d; n++;
  endtask

  task automatic buildExp(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                          input logic [DATA_W-1:0] d, input int cnt,
                          input logic [DATA_W-1:0] wb, input int startCnt, output int n);
    n = 0;
    case (op)
      3'd0: begin
        if (!bypModel) begin push(n, 24'h555, 16'h00AA); push(n, 24'h2AA, 16'h0055); end
        push(n, 24'h555, 16'h00A0); push(n, a, d);
      end
      3'd1: begin
        if (!bypModel) begin push(n, 24'h555, 16'h00AA); push(n, 24'h2AA, 16'h0055); end
        push(n, a, 16'h0025); push(n, a, DATA_W'(cnt - 1));
        for (int i = 0; i < cnt; i++) push(n, a + ADDR_W'(i), wb + DATA_W'(startCnt + i));
        push(n, a, 16'h0029);
      end
      3'd2: if (!bypModel) begin
        push(n, 24'h555, 16'h00AA); push(n, 24'h2AA, 16'h0055); push(n, 24'h555, 16'h0020);
        bypModel = 1;
      end
      3'd3: if (bypModel) begin
        push(n, 24'h000, 16'h0090); push(n, 24'h000, 16'h0000);
        bypModel = 0;
      end
      default: begin
        push(n, 24'h555, 16'h00AA); push(n, 24'h2AA, 16'h0055); push(n, 24'h555, 16'h0080);
        push(n, 24'h555, 16'h00AA); push(n, 24'h2AA, 16'h0055);
        if (op == 3'd5) push(n, 24'h555, 16'h0010); else push(n, a, 16'h0030);
      end
    endcase
  endtask

  // issue one request; returns the reject flag seen one cycle after acceptance
  task automatic issue(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                       input logic [DATA_W-1:0] d, input logic [BCNT_W-1:0] c,
                       output bit rej, output bit readyDropped);
    int guard;
    guard = 0;
    while (!reqReady && guard < 1000) begin tick(); guard++; end
    reqOp = op; reqAddr = a; reqData = d; reqCount = c; reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
    rej = reqReject;
    readyDropped = !reqReady;
    guard = 0;
    while (!reqReady && guard < 1000) begin tick(); guard++; end
  endtask

  typedef struct packed {
    logic [2:0]  op;
    logic [23:0] addr;
    logic [15:0] data;
    logic [3:0]  cnt;
    logic [15:0] wbase;
    logic        expRej;
    logic [7:0]  expN;
    logic [7:0]  req;
  } vecS;

  localparam vecS VEC [15] = '{
    '{3'd0, 24'h001234, 16'hBEEF, 4'd0, 16'h0000, 1'b0, 8'd4, 8'd2},   // R2 standard program
    '{3'd2, 24'h000000, 16'h0000, 4'd0, 16'h0000, 1'b0, 8'd3, 8'd6},   // R6 enter
    '{3'd2, 24'h000000, 16'h0000, 4'd0, 16'h0000, 1'b0, 8'd0, 8'd6},   // R6 enter again
    '{3'd0, 24'h000010, 16'h1111, 4'd0, 16'h0000, 1'b0, 8'd2, 8'd6},   // R6 bypass program
    '{3'd1, 24'h000100, 16'h0000, 4'd3, 16'h5000, 1'b0, 8'd6, 8'd8},   // R8 bypass buffer
    '{3'd4, 24'h020000, 16'h0000, 4'd0, 16'h0000, 1'b1, 8'd0, 8'd11},  // R11 erase in bypass
    '{3'd3, 24'h000000, 16'h0000, 4'd0, 16'h0000, 1'b0, 8'd2, 8'd7},   // R7 exit
    '{3'd3, 24'h000000, 16'h0000, 4'd0, 16'h0000, 1'b0, 8'd0, 8'd7},   // R7 exit again
    '{3'd1, 24'h000200, 16'h0000, 4'd4, 16'h7700, 1'b0, 8'd9, 8'd8},   // R8 full buffer
    '{3'd1, 24'h000300, 16'h0000, 4'd5, 16'h0000, 1'b1, 8'd0, 8'd9},   // R9 over length
    '{3'd1, 24'h000300, 16'h0000, 4'd0, 16'h0000, 1'b1, 8'd0, 8'd9},   // R9 zero length
    '{3'd4, 24'h020000, 16'h0000, 4'd0, 16'h0000, 1'b0, 8'd6, 8'd10},  // R10 sector erase
    '{3'd5, 24'h030000, 16'h0000, 4'd0, 16'h0000, 1'b0, 8'd6, 8'd10},  // R10 chip erase
    '{3'd6, 24'h000000, 16'h0000, 4'd0, 16'h0000, 1'b1, 8'd0, 8'd9},   // R9 bad opcode
    '{3'd0, 24'h00ABCD, 16'h4242, 4'd0, 16'h0000, 1'b0, 8'd4, 8'd7}    // R7 four cycles again
  };

  initial begin
    bit rej, dropped;
    int base, n, startCnt, guard;
    string tag;

    repeat (3) tick();
    // R1: reset state
    chk("R1", "reqReady", reqReady, 1);
    chk("R1", "flashCeN", flashCeN, 1);
    chk("R1", "flashWeN", flashWeN, 1);
    chk("R1", "flashOeN", flashOeN, 1);
    chk("R1", "reqReject", reqReject, 0);
    chk("R1", "wordReady", wordReady, 0);
    rstN = 1'b1;
    tick();
    chk("R1", "reqReady after release", reqReady, 1);

    foreach (VEC[k]) begin
      tag = $sformatf("R%0d", VEC[k].req);
      wordBase = VEC[k].wbase;
      startCnt = wordCnt;
      base = logN;
      issue(VEC[k].op, VEC[k].addr, VEC[k].data, BCNT_W'(VEC[k].cnt), rej, dropped);
      chk(tag, $sformatf("vec%0d reject", k), rej, VEC[k].expRej);
      chk("R5", $sformatf("vec%0d ready dropped", k), dropped, 1);
      chk(tag, $sformatf("vec%0d write count", k), logN - base, VEC[k].expN);
      if (!VEC[k].expRej) begin
        buildExp(VEC[k].op, VEC[k].addr, VEC[k].data, int'(VEC[k].cnt), VEC[k].wbase, startCnt, n);
        for (int i = 0; i < n && i < int'(VEC[k].expN); i++) begin
          chk(tag, $sformatf("vec%0d write%0d addr", k, i), logA[(base + i) % LOGSZ], expA[i]);
          chk(tag, $sformatf("vec%0d write%0d data", k, i), logD[(base + i) % LOGSZ], expD[i]);
        end
      end
    end

    // R4: low 3 / high 2 on a standard program
    cfgLowCycles = 4'd3; cfgHighCycles = 4'd2;
    base = logN;
    issue(3'd0, 24'h000040, 16'h0F0F, '0, rej, dropped);
    chk("R4", "writes", logN - base, 4);
    for (int i = 0; i < 4; i++) chk("R4", $sformatf("low len %0d", i), logLow[(base + i) % LOGSZ], 3);
    for (int i = 1; i < 4; i++) chk("R4", $sformatf("gap %0d", i), logGap[(base + i) % LOGSZ], 2);
    chk("R5", "tail high time", gapRun, 2);

    // R4: zero settings behave as one
    cfgLowCycles = 4'd0; cfgHighCycles = 4'd0;
    base = logN;
    issue(3'd0, 24'h000041, 16'h0E0E, '0, rej, dropped);
    chk("R4", "writes zero cfg", logN - base, 4);
    for (int i = 0; i < 4; i++) chk("R4", $sformatf("low len zero %0d", i), logLow[(base + i) % LOGSZ], 1);
    for (int i = 1; i < 4; i++) chk("R4", $sformatf("gap zero %0d", i), logGap[(base + i) % LOGSZ], 1);
    chk("R5", "tail zero cfg", gapRun, 1);

    // R8: stalled word source
    cfgLowCycles = 4'd1; cfgHighCycles = 4'd1;
    wordValid = 1'b0;
    wordBase = 16'h9A00;
    startCnt = wordCnt;
    base = logN;
    reqOp = 3'd1; reqAddr = 24'h000500; reqCount = BCNT_W'(1); reqValid = 1'b1;
    tick();
    reqValid = 1'b0;
    guard = 0;
    while (!wordReady && guard < 100) begin tick(); guard++; end
    chk("R8", "wordReady raised", wordReady, 1);
    repeat (5) begin
      tick();
      chk("R8", "strobe high while stalled", flashWeN, 1);
    end
    chk("R8", "writes before word", logN - base, 4);
    wordValid = 1'b1;
    guard = 0;
    while (!reqReady && guard < 100) begin tick(); guard++; end
    chk("R8", "writes after word", logN - base, 6);
    chk("R8", "word addr", logA[(base + 4) % LOGSZ], 24'h000500);
    chk("R8", "word data", logD[(base + 4) % LOGSZ], 16'h9A00 + DATA_W'(startCnt));

    // R3: strobe pairing and output enable over the whole run
    chk("R3", "ce high during we low", ceBad, 0);
    chk("R3", "oe driven low", oeBad, 0);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule